// File: doc/BRIEF.md
# GPIO Pad Event Interrupt Controller

This block serves one group of general-purpose pads, one pad per bit. Each pad has a configuration word of its own. The word sets the output value, turns the output driver and the input receiver on or off, and chooses how input activity becomes an event. The choices are level, single edge, both edges or off, with an optional input inversion. Inverting the input turns a rising edge into a falling edge and an active-high level into an active-low level.

Every pad input passes through a two-flop synchroniser before detection. A detected event latches a per-pad bit in a shared status register, and software clears that bit by writing a one to it. A shared enable register masks the status bits. A single interrupt line is high while any pad has both its status bit and its enable bit set. The group may be only partly populated. Bit positions at or above the populated count never report an event.

Software reaches all registers through a single-cycle write port and a combinational read port. Pad configuration words sit at addresses 0 to NUM_PADS-1, the status register at 0x20 and the enable register at 0x21.

Top module: `gpio_event_ctrl`

## Requirements
- R1: After reset, status and enable read 0, irq is 0, pad_oe is 0, and every pad word reads 0x04000100 (detection off, driver off).
- R2: In a pad word, bit 0 drives pad_out and bit 8 set disables the driver (pad_oe is the inverse of bit 8). Bit 1 is read-only and returns the synchronised input level.
- R3: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R4: irq is 1 exactly when some pad has both its status bit and its enable bit set.
- R5: Mode value 0 (bits 26:25) is level detection: the status bit is set on every cycle the input, after inversion, is high.
- R6: Mode value 1 is single-edge detection: a rising transition of the input after inversion sets status, so bit 23 set selects a falling edge.
- R7: Mode value 3 detects both transitions of the input.
- R8: Mode value 2 produces no events.
- R9: If an event and a clearing write reach the same status bit in the same cycle, the bit stays set.
- R10: With bit 9 set, the receiver is off: the pad produces no events and bit 1 reads 0.
- R11: Status bits at positions PADS_USED and above never become set.
- R12: An input change shows in bit 1 after two clock edges and sets status on the third edge. Register writes take effect on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pad_in | input | NUM_PADS | Raw asynchronous pad inputs |
| pad_out | output | NUM_PADS | Pad output values |
| pad_oe | output | NUM_PADS | Pad output enables |
| irq | output | 1 | Group interrupt |

## Verification
An input change needs three rising edges to reach the status register: two for the synchroniser and one for the status flop. It is visible in bit 1 after two. Register writes show one edge later, and the read port and irq follow their registers within the same cycle. The bench drives inputs on falling edges and then counts an exact number of falling edges before it samples. The latency test samples one edge before the expected change and again at the change, so results that arrive early or late are both caught. Each table row holds its input steady for four edges before it configures the pad, so a configuration write never sees an input transition still in flight.

// File: rtl/gpev_pkg.sv
package gpev_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 6;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 6'h20;
    localparam logic [ADDR_W-1:0] ADDR_ENABLE = 6'h21;

    localparam int POS_TXVAL = 0;
    localparam int POS_RXST  = 1;
    localparam int POS_TXOFF = 8;
    localparam int POS_RXOFF = 9;
    localparam int POS_INV   = 23;
    localparam int POS_MODE  = 25;

    typedef enum logic [1:0] {
        EVM_LEVEL = 2'd0,
        EVM_EDGE  = 2'd1,
        EVM_OFF   = 2'd2,
        EVM_BOTH  = 2'd3
    } evmode_e;

    typedef struct packed {
        evmode_e mode;
        logic    inv;
        logic    rx_off;
        logic    tx_off;
        logic    tx_val;
    } padcfg_t;

    localparam padcfg_t CFG_RESET = '{mode: EVM_OFF, inv: 1'b0, rx_off: 1'b0,
                                      tx_off: 1'b1, tx_val: 1'b0};

    function automatic padcfg_t unpack_cfg(input logic [DATA_W-1:0] w);
        padcfg_t c;
        c.mode   = evmode_e'(w[POS_MODE +: 2]);
        c.inv    = w[POS_INV];
        c.rx_off = w[POS_RXOFF];
        c.tx_off = w[POS_TXOFF];
        c.tx_val = w[POS_TXVAL];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] pack_cfg(input padcfg_t c, input logic rx);
        logic [DATA_W-1:0] w;
        w               = '0;
        w[POS_MODE +: 2] = c.mode;
        w[POS_INV]      = c.inv;
        w[POS_RXOFF]    = c.rx_off;
        w[POS_TXOFF]    = c.tx_off;
        w[POS_RXST]     = rx;
        w[POS_TXVAL]    = c.tx_val;
        return w;
    endfunction

    // cur/prv are the post-inversion levels of this and the previous cycle
    function automatic logic detect(input evmode_e m, input logic cur, input logic prv);
        case (m)
            EVM_LEVEL: return cur;
            EVM_EDGE:  return cur & ~prv;
            EVM_BOTH:  return cur ^ prv;
            default:   return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/gpev_pad_chan.sv
module gpev_pad_chan
    import gpev_pkg::*;
#(
    parameter bit POPULATED = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              pad_in,
    output logic [DATA_W-1:0] cfg_rd,
    output logic              event_o,
    output logic              rx_off_o,
    output logic              pad_out,
    output logic              pad_oe
);
    padcfg_t    cfg_q;
    logic [2:0] smp_q;   // [0],[1] synchroniser, [2] previous synchronised level
    logic       rx_lvl;
    logic       cur_lvl;
    logic       prv_lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
            smp_q <= '0;
        end else begin
            if (cfg_we) cfg_q <= unpack_cfg(cfg_wdata);
            smp_q <= {smp_q[1:0], pad_in};
        end
    end

    always_comb begin
        rx_lvl  = smp_q[1] & ~cfg_q.rx_off;
        cur_lvl = smp_q[1] ^ cfg_q.inv;
        prv_lvl = smp_q[2] ^ cfg_q.inv;
    end

    generate
        if (POPULATED) begin : g_live
            assign event_o = ~cfg_q.rx_off & detect(cfg_q.mode, cur_lvl, prv_lvl);
        end else begin : g_absent
            assign event_o = 1'b0;
        end
    endgenerate

    assign cfg_rd   = pack_cfg(cfg_q, rx_lvl);
    assign rx_off_o = cfg_q.rx_off;
    assign pad_out  = cfg_q.tx_val;
    assign pad_oe   = ~cfg_q.tx_off;
endmodule

// File: rtl/gpev_status.sv
module gpev_status #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] ev,
    input  logic         st_we,
    input  logic         en_we,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] status,
    output logic [N-1:0] enable,
    output logic         irq
);
    logic [N-1:0] clr;

    assign clr = st_we ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            enable <= '0;
        end else begin
            status <= (status & ~clr) | ev;   // new event beats the clear
            if (en_we) enable <= wdata;
        end
    end

    assign irq = |(status & enable);
endmodule

// File: rtl/gpio_event_ctrl.sv
module gpio_event_ctrl
    import gpev_pkg::*;
#(
    parameter int NUM_PADS  = 16,
    parameter int PADS_USED = 13
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [NUM_PADS-1:0] pad_in,
    output logic [NUM_PADS-1:0] pad_out,
    output logic [NUM_PADS-1:0] pad_oe,
    output logic                irq
);
    logic [DATA_W-1:0]   cfg_words [NUM_PADS];
    logic [NUM_PADS-1:0] ev_vec;
    logic [NUM_PADS-1:0] rxoff_vec;
    logic [NUM_PADS-1:0] status_q;
    logic [NUM_PADS-1:0] enable_q;
    logic                wr_status;
    logic                wr_enable;

    assign wr_status = reg_we && (reg_addr == ADDR_STATUS);
    assign wr_enable = reg_we && (reg_addr == ADDR_ENABLE);

    generate
        for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
            gpev_pad_chan #(.POPULATED(i < PADS_USED)) u_chan (
                .clk      (clk),
                .rst      (rst),
                .cfg_we   (reg_we && (reg_addr == ADDR_W'(i))),
                .cfg_wdata(reg_wdata),
                .pad_in   (pad_in[i]),
                .cfg_rd   (cfg_words[i]),
                .event_o  (ev_vec[i]),
                .rx_off_o (rxoff_vec[i]),
                .pad_out  (pad_out[i]),
                .pad_oe   (pad_oe[i])
            );
        end
    endgenerate

    gpev_status #(.N(NUM_PADS)) u_status (
        .clk   (clk),
        .rst   (rst),
        .ev    (ev_vec),
        .st_we (wr_status),
        .en_we (wr_enable),
        .wdata (reg_wdata[NUM_PADS-1:0]),
        .status(status_q),
        .enable(enable_q),
        .irq   (irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_STATUS)            reg_rdata = DATA_W'(status_q);
        else if (reg_addr == ADDR_ENABLE)       reg_rdata = DATA_W'(enable_q);
        else if (reg_addr < ADDR_W'(NUM_PADS))  reg_rdata = cfg_words[reg_addr[$clog2(NUM_PADS)-1:0]];
    end
endmodule

// File: rtl/gpev_checker.sv
module gpev_checker #(
    parameter int N    = 16,
    parameter int USED = 13
) (
    input logic         clk,
    input logic         rst,
    input logic         irq,
    input logic         wr_status,
    input logic [N-1:0] ev_vec,
    input logic [N-1:0] rxoff_vec,
    input logic [N-1:0] status_q,
    input logic [N-1:0] enable_q
);
    localparam logic [N-1:0] DEAD_MASK = ~((N'(1) << USED) - N'(1));

    AST_NO_SILENT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !wr_status |=> ((status_q & $past(status_q)) == $past(status_q))); // R3

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((status_q & enable_q) != '0)); // R4

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
        (ev_vec != '0) |=> ((status_q & $past(ev_vec)) == $past(ev_vec))); // R9

    AST_RX_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        (ev_vec & rxoff_vec) == '0); // R10

    AST_DEAD_PADS: assert property (@(posedge clk) disable iff (rst)
        (status_q & DEAD_MASK) == '0); // R11
endmodule

bind gpio_event_ctrl gpev_checker #(.N(NUM_PADS), .USED(PADS_USED)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .irq      (irq),
    .wr_status(wr_status),
    .ev_vec   (ev_vec),
    .rxoff_vec(rxoff_vec),
    .status_q (status_q),
    .enable_q (enable_q)
);

// File: tb/gpio_event_ctrl_test.sv
`timescale 1ns/1ps
module gpio_event_ctrl_test;
    localparam int NP = 16;
    localparam int NU = 13;
    localparam int NV = 14;
    localparam logic [5:0] A_ST = 6'h20;
    localparam logic [5:0] A_EN = 6'h21;

    // {mode[1:0], invert, level before, level after, expected status}
    localparam logic [5:0] VEC [NV] = '{
        6'b00_0_011, 6'b00_0_000, 6'b00_1_110, 6'b00_1_101,
        6'b01_0_011, 6'b01_0_100, 6'b01_1_101, 6'b01_1_010,
        6'b11_0_011, 6'b11_0_101, 6'b11_0_110,
        6'b10_0_010, 6'b10_1_100, 6'b00_1_001
    };

    logic          clk = 0;
    logic          rst = 1;
    logic          reg_we = 0;
    logic [5:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out, pad_oe;
    logic          irq;
    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    gpio_event_ctrl #(.NUM_PADS(NP), .PADS_USED(NU)) uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic string mode_req(input logic [1:0] m);
        case (m)
            2'd0: return "R5 level";
            2'd1: return "R6 edge";
            2'd3: return "R7 both";
            default: return "R8 off";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        tick(3);
        rst = 0;
        tick(1);
        // R1 reset state
        rd(6'd0, d);   check("R1 cfg reset", d, 32'h0400_0100);
        rd(A_ST, d);   check("R1 status reset", d, 0);
        rd(A_EN, d);   check("R1 enable reset", d, 0);
        check("R1 irq reset", {31'b0, irq}, 0);
        check("R1 oe reset", 32'(pad_oe), 0);

        // R2 output value and driver enable
        wr(6'd2, 32'h0400_0001);
        check("R2 pad_out", 32'(pad_out[2]), 1);
        check("R2 pad_oe", 32'(pad_oe[2]), 1);
        // R2 / R12 input state reaches bit 1 after two edges
        pad_in[2] = 1;
        tick(1); rd(6'd2, d); check("R12 rx one edge", 32'(d[1]), 0);
        tick(1); rd(6'd2, d); check("R2 rx two edges", 32'(d[1]), 1);
        pad_in[2] = 0;
        wr(6'd2, 32'h0400_0100);

        // vector table: R5..R8 with enable on for R4
        wr(A_EN, 32'h0000_FFFF);
        for (int r = 0; r < NV; r++) begin
            int p;
            logic [1:0] m;
            p = r % NU;
            m = VEC[r][5:4];
            pad_in[p] = VEC[r][2];
            tick(4);
            wr(6'(p), (32'(m) << 25) | (32'(VEC[r][3]) << 23));
            wr(A_ST, 32'h0000_FFFF);
            pad_in[p] = VEC[r][1];
            tick(4);
            rd(A_ST, d);
            check(mode_req(m), 32'(d[p]), 32'(VEC[r][0]));
            check("R4 irq follows status", {31'b0, irq}, 32'(VEC[r][0]));
            wr(6'(p), 32'h0400_0100);
            pad_in[p] = 0;
            tick(4);
            wr(A_ST, 32'h0000_FFFF);
        end

        // R12 status latency: three edges after input change
        wr(6'd4, 32'h0200_0000);
        tick(4);
        pad_in[4] = 1;
        tick(2); rd(A_ST, d); check("R12 status not early", 32'(d[4]), 0);
        tick(1); rd(A_ST, d); check("R12 status on third edge", 32'(d[4]), 1);
        // R3 writing zero keeps, writing one elsewhere keeps
        wr(A_ST, 32'h0);      rd(A_ST, d); check("R3 write 0 keeps", 32'(d[4]), 1);
        wr(A_ST, 32'h0008);   rd(A_ST, d); check("R3 other bit keeps", 32'(d[4]), 1);
        // R4 mask
        wr(A_EN, 32'h0);      check("R4 masked irq", {31'b0, irq}, 0);
        wr(A_EN, 32'h0010);   check("R4 enabled irq", {31'b0, irq}, 1);
        wr(A_ST, 32'h0010);   rd(A_ST, d); check("R3 write 1 clears", 32'(d[4]), 0);
        check("R4 irq drops", {31'b0, irq}, 0);
        wr(6'd4, 32'h0400_0100);
        pad_in[4] = 0;

        // R9 event wins over clear in level mode
        pad_in[5] = 1;
        tick(4);
        wr(6'd5, 32'h0000_0000);
        wr(A_ST, 32'h0020);   rd(A_ST, d); check("R9 event beats clear", 32'(d[5]), 1);
        pad_in[5] = 0;
        tick(4);
        wr(A_ST, 32'h0020);   rd(A_ST, d); check("R9 clear after release", 32'(d[5]), 0);
        wr(6'd5, 32'h0400_0100);

        // R10 receiver off
        wr(6'd6, 32'h0000_0200);
        pad_in[6] = 1;
        tick(5);
        rd(A_ST, d);  check("R10 no event", 32'(d[6]), 0);
        rd(6'd6, d);  check("R10 rx reads 0", 32'(d[1]), 0);
        pad_in[6] = 0;
        wr(6'd6, 32'h0400_0100);

        // R11 unpopulated pad
        wr(A_EN, 32'h0000_FFFF);
        wr(6'd14, 32'h0000_0000);
        pad_in[14] = 1;
        tick(5);
        rd(A_ST, d);  check("R11 dead pad quiet", 32'(d[14]), 0);
        check("R11 irq quiet", {31'b0, irq}, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule